// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt lines from around the chip and reduces them to one interrupt request for the processor. The lines are grouped into banks of 32. For each bank, software can read the synchronized line levels and a mask word. It can change the mask either by writing the whole word or through two write-one aliases, one that sets mask bits and one that clears them. A pending word shows the lines that are both high and unmasked.

The request output is a held flag. It rises by itself as soon as any unmasked line is high. Once it is high, it stays high until software writes the agreement bit of the control register. That write makes the controller look again: if something is still pending the flag stays up, and otherwise it drops. The usual handler sequence is to read the pending words, service the sources, and then write the agreement bit.

The number of banks is a build parameter. Addresses of banks that are not built behave as empty space. The register port is a plain one-word request interface with no back-pressure. A write completes in the cycle its strobe is sampled. Read data is registered and appears on the cycle after the read strobe is sampled.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every pending word reads 0 and `irq_out` is low.
- R2: Bank n occupies byte addresses 0x80 + n*0x20 onwards. Within a bank, the line levels are at +0x00, the mask at +0x04, the clear alias at +0x08, the set alias at +0x0C and the pending word at +0x18. Bit i of every word refers to line 32*n + i.
- R3: A write to the clear alias clears each mask bit whose data bit is 1, which enables that line. Mask bits whose data bit is 0 keep their value.
- R4: A write to the set alias sets each mask bit whose data bit is 1, which disables that line. Mask bits whose data bit is 0 keep their value.
- R5: The pending word equals the line-level word ANDed with the inverted mask. A masked line never appears in it.
- R6: Each line passes through a two-flop synchronizer before it reaches the line-level word. A read issued three cycles after a line changes returns the new level.
- R7: While `irq_out` is low, it goes high on the clock edge after any unmasked line is high, with no software action.
- R8: Once `irq_out` is high, it stays high until an agreement write, even if every pending line goes away.
- R9: A write to the control register at 0x48 with data bit 0 = 1 is an agreement write. It sets `irq_out` to whether any line is pending in that cycle. A write to 0x48 with bit 0 = 0 changes nothing.
- R10: Reads of both aliases and of the control register return 0. Accesses to undefined offsets, unaligned addresses or banks at or above NUM_BANKS read 0, and writes to them change no state.
- R11: A write to the mask offset replaces the whole mask word, and a read of that offset returns the current mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_BANKS*32 | Level-sensitive interrupt lines, bit k is line k |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_rd_en | input | 1 | Read strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_out | output | 1 | Held interrupt request to the processor |

## Verification
The assertions assume that the register port never raises read and write in the same cycle. They also assume that the address is stable while a strobe is high. The interrupt lines are assumed to be free to change at any time, because the synchronizer absorbs them. The stimulus drives each access as a single-cycle strobe launched on the falling edge, with only one strobe high at a time. It changes the lines only between accesses and then waits out the synchronizer depth before it predicts line levels or the request state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned BANK_SLOT0   = 4;      // first bank at 0x80, stride 0x20
  localparam int unsigned CTRL_ADDR    = 'h48;
  localparam int unsigned AGREE_BIT    = 0;

  localparam logic [4:0] OFS_LEVEL = 5'h00;
  localparam logic [4:0] OFS_MASK  = 5'h04;
  localparam logic [4:0] OFS_MCLR  = 5'h08;
  localparam logic [4:0] OFS_MSET  = 5'h0C;
  localparam logic [4:0] OFS_PEND  = 5'h18;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_LEVEL,
    FLD_MASK,
    FLD_MCLR,
    FLD_MSET,
    FLD_PEND
  } fld_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqc_regdec.sv
module irqc_regdec
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]    addr,
  output fld_e                 fld,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic                 ctrl_hit
);
  localparam int unsigned SLOT_W = ADDR_W - 5;

  logic [SLOT_W-1:0] slot;
  logic [4:0]        ofs;

  assign slot = addr[ADDR_W-1:5];
  assign ofs  = addr[4:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign bank_sel[b] = (slot == SLOT_W'(BANK_SLOT0 + b));
  end

  always_comb begin
    fld = FLD_NONE;
    if (|bank_sel) begin
      case (ofs)
        OFS_LEVEL: fld = FLD_LEVEL;
        OFS_MASK:  fld = FLD_MASK;
        OFS_MCLR:  fld = FLD_MCLR;
        OFS_MSET:  fld = FLD_MSET;
        OFS_PEND:  fld = FLD_PEND;
        default:   fld = FLD_NONE;
      endcase
    end
  end

  assign ctrl_hit = (addr == ADDR_W'(CTRL_ADDR));
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src,
  input  logic              wr_en,
  input  fld_e              fld,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] level,
  output logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] pend
);
  irqc_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src),
    .q     (level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (wr_en) begin
      case (fld)
        FLD_MASK: mask <= wdata;
        FLD_MCLR: mask <= mask & ~wdata;
        FLD_MSET: mask <= mask | wdata;
        default:  mask <= mask;
      endcase
    end
  end

  assign pend = level & ~mask;
endmodule

// File: rtl/irqc_reqflag.sv
module irqc_reqflag (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic agree,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (agree)    irq <= any_pend;
    else if (any_pend) irq <= 1'b1;
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 3,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*WORD_W-1:0] irq_src,
  input  logic                        reg_wr_en,
  input  logic                        reg_rd_en,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [WORD_W-1:0]           reg_wdata,
  output logic [WORD_W-1:0]           reg_rdata,
  output logic                        irq_out
);
  localparam int unsigned NSRC = NUM_BANKS * WORD_W;

  fld_e                 fld;
  logic [NUM_BANKS-1:0] bank_sel;
  logic                 ctrl_hit;
  logic [NSRC-1:0]      level_flat;
  logic [NSRC-1:0]      mask_flat;
  logic [NSRC-1:0]      pend_flat;
  logic                 agree;
  logic [WORD_W-1:0]    rd_val;

  irqc_regdec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr     (reg_addr),
    .fld      (fld),
    .bank_sel (bank_sel),
    .ctrl_hit (ctrl_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqc_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (irq_src[b*WORD_W +: WORD_W]),
      .wr_en (reg_wr_en & bank_sel[b]),
      .fld   (fld),
      .wdata (reg_wdata),
      .level (level_flat[b*WORD_W +: WORD_W]),
      .mask  (mask_flat[b*WORD_W +: WORD_W]),
      .pend  (pend_flat[b*WORD_W +: WORD_W])
    );
  end

  assign agree = reg_wr_en & ctrl_hit & reg_wdata[AGREE_BIT];

  irqc_reqflag u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_pend (|pend_flat),
    .agree    (agree),
    .irq      (irq_out)
  );

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        case (fld)
          FLD_LEVEL: rd_val = level_flat[b*WORD_W +: WORD_W];
          FLD_MASK:  rd_val = mask_flat[b*WORD_W +: WORD_W];
          FLD_PEND:  rd_val = pend_flat[b*WORD_W +: WORD_W];
          default:   rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr_en,
  input logic                     reg_rd_en,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [31:0]              reg_wdata,
  input logic [31:0]              reg_rdata,
  input logic                     irq_out,
  input logic [NUM_BANKS*32-1:0]  mask_flat,
  input logic [NUM_BANKS*32-1:0]  pend_flat
);
  logic agree_wr;
  logic any_p;
  assign agree_wr = reg_wr_en && (reg_addr == ADDR_W'('h48)) && reg_wdata[0];
  assign any_p    = |pend_flat;

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_W'('h88)) |=> ((mask_flat[31:0] & $past(reg_wdata)) == 32'h0)); // R3

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_W'('h8C)) |=> ((mask_flat[31:0] & $past(reg_wdata)) == $past(reg_wdata))); // R4

  AST_PEND_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == ADDR_W'('h98)) |=> ((reg_rdata & $past(mask_flat[31:0])) == 32'h0)); // R5

  AST_AUTO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && any_p) |=> irq_out); // R7

  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !agree_wr) |=> irq_out); // R8

  AST_AGREE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (agree_wr && !any_p) |=> !irq_out); // R9

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && (reg_addr == ADDR_W'('h88) || reg_addr == ADDR_W'('h8C) || reg_addr == ADDR_W'('h48)))
      |=> (reg_rdata == 32'h0)); // R10
endmodule

bind banked_irq_ctrl irqc_checker #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .mask_flat (mask_flat),
  .pend_flat (pend_flat)
);

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;
  localparam int unsigned NB = 3;
  localparam int unsigned AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB*32-1:0] irq_src = '0;
  logic            reg_wr_en = 1'b0;
  logic            reg_rd_en = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) i_banked_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // driver: pushes the expected word and issues the read
  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_out !== exp) begin
      fails++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops expected words as read data appears
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd_en) begin
        @(negedge clk);
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL scoreboard empty actual=%08h expected=none", reg_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s rdata actual=%08h expected=%08h", t, reg_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(12'h084, 32'hFFFF_FFFF, "R1 mask0");
    rd(12'h0A4, 32'hFFFF_FFFF, "R1 mask1");
    rd(12'h0C4, 32'hFFFF_FFFF, "R1 mask2");
    rd(12'h098, 32'h0, "R1 pend0");

    // R6 / R2 line levels through the synchronizer
    irq_src[31:0]  = 32'h0000_00F0;
    irq_src[63:32] = 32'h8000_0001;
    idle(3);
    rd(12'h080, 32'h0000_00F0, "R6 level0");
    rd(12'h0A0, 32'h8000_0001, "R2 level1");
    rd(12'h098, 32'h0, "R5 masked pend0");
    chk_irq(1'b0, "R7 all masked");

    // R3 clear alias
    wr(12'h088, 32'h0000_0030);
    rd(12'h084, 32'hFFFF_FFCF, "R3 mask0");
    chk_irq(1'b1, "R7 auto rise");
    rd(12'h098, 32'h0000_0030, "R5 pend0");

    // R4 set alias
    wr(12'h08C, 32'h0000_0010);
    rd(12'h084, 32'hFFFF_FFDF, "R4 mask0");
    rd(12'h098, 32'h0000_0020, "R5 pend0 after set");

    // R8 hold, R9 agreement
    wr(12'h08C, 32'h0000_0020);
    rd(12'h098, 32'h0, "R5 pend0 none");
    idle(3);
    chk_irq(1'b1, "R8 held");
    wr(12'h048, 32'h0000_0000);
    idle(2);
    chk_irq(1'b1, "R9 bit0 clear no effect");
    wr(12'h048, 32'h0000_0001);
    chk_irq(1'b0, "R9 agree drop");

    // R9 agreement with pending keeps request
    wr(12'h0A8, 32'h0000_0001);
    idle(1);
    chk_irq(1'b1, "R7 bank1 rise");
    rd(12'h0B8, 32'h0000_0001, "R5 pend1");
    wr(12'h048, 32'h0000_0001);
    idle(1);
    chk_irq(1'b1, "R9 agree keeps");
    irq_src[32] = 1'b0;
    idle(4);
    chk_irq(1'b1, "R8 held after line low");
    rd(12'h0B8, 32'h0, "R6 pend1 gone");
    wr(12'h048, 32'h0000_0001);
    chk_irq(1'b0, "R9 agree drop 2");

    // R11 whole-word mask write
    wr(12'h0C4, 32'h1234_5678);
    rd(12'h0C4, 32'h1234_5678, "R11 mask2");
    irq_src[95:64] = 32'h0000_0081;
    idle(3);
    rd(12'h0D8, 32'h0000_0081, "R5 pend2");
    chk_irq(1'b1, "R7 bank2 rise");

    // R10 zero reads and ignored writes
    rd(12'h088, 32'h0, "R10 clr alias");
    rd(12'h08C, 32'h0, "R10 set alias");
    rd(12'h048, 32'h0, "R10 ctrl");
    rd(12'h090, 32'h0, "R10 undefined offset");
    rd(12'h0E0, 32'h0, "R10 absent bank");
    wr(12'h0E4, 32'h0);
    wr(12'h0E8, 32'hFFFF_FFFF);
    wr(12'h090, 32'h0);
    wr(12'h085, 32'h0);
    rd(12'h0E4, 32'h0, "R10 absent mask");
    rd(12'h084, 32'hFFFF_FFFF, "R10 mask0 kept");
    rd(12'h0A4, 32'hFFFF_FFFE, "R10 mask1 kept");
    rd(12'h0C4, 32'h1234_5678, "R10 mask2 kept");

    idle(3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule